// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block is the central arbiter of one shared parallel bus segment. It decides which of seven masters may drive the bus next. Six of them are external agents, each with an active-low request and an active-low grant. The seventh is the bridge itself, which requests and is granted through active-high internal signals. A configuration vector places each agent in a high-priority or a low-priority rotation. The high rotation is served round-robin. It holds one extra slot that stands for the whole low group, and the low group is rotated round-robin each time that slot comes up.

A programmable hold timer lets the current owner keep the bus for back-to-back transactions. A watchdog on the start of a transaction takes the grant away from a master that never begins one. When nobody requests, the grant parks either on the previous owner or on the bridge, selected by a configuration bit. Grant changes happen only on an idle bus, or when the owner has withdrawn its request.

Top module: `bus_arbiter`

## Requirements
- R1: Each request passes through one register before it is used. With the bus idle and no other requester, the grant for a newly asserted request appears after the second rising clock edge. Grants are driven from flip-flops.
- R2: Exactly one of the seven grants is asserted in every cycle, and reset leaves the bridge granted. Agent index i (0 to 5) maps to bit i of `req_n` and `gnt_n`. The bridge is agent 6.
- R3: When several high-level agents compete and the hold count is zero, they are granted in increasing index order. The order wraps from agent 6 to the low-group slot and then to agent 0, and starts after the last slot served.
- R4: Bit i of `hi_pri` set to 1 puts agent i in the high rotation; set to 0 it puts agent i in the low group. Each turn of the low-group slot grants the next requesting low agent in increasing index order, wrapping around.
- R5: With `park_last` at 0 and no requests, the grant returns to the bridge.
- R6: With `park_last` at 1 and no requests, the grant stays with the last owner.
- R7: While the owner is still requesting, the grant does not move unless FRAME (`frame_n`) and IRDY (`irdy_n`) are both high.
- R8: A new grant loads `mtt_load` into the hold counter, which counts down once per clock. While the count is nonzero and the owner still requests, no other requester takes the bus.
- R9: When the owner withdraws its request, arbitration takes place on the next edge at which the registered request has fallen, even if the hold count is nonzero.
- R10: If the owner keeps requesting but `frame_n` stays high for 16 clocks after the grant, the grant moves to the next waiting requester, regardless of the hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_n | input | 6 | Active-low requests of external agents 0 to 5 |
| bridge_req | input | 1 | Request of the bridge (agent 6), active high |
| frame_n | input | 1 | Bus FRAME, active low |
| irdy_n | input | 1 | Bus IRDY, active low |
| hi_pri | input | 7 | Per-agent level: 1 means high rotation, 0 means low group |
| park_last | input | 1 | 1 parks on the last owner, 0 parks on the bridge |
| mtt_load | input | 8 | Hold-timer reload value |
| gnt_n | output | 6 | Active-low grants of external agents 0 to 5 |
| bridge_gnt | output | 1 | Grant of the bridge, active high |

## Verification
The assertions assume that `frame_n` and `irdy_n` describe the bus the granted master drives. They also assume that the configuration inputs may change on any cycle, with the effect taking place at the next arbitration decision. The stimulus keeps requests steady for several cycles at a time, so that hold expiry and the dead-master path are both reached. It drives FRAME and IRDY busy only part of the time, so that idle windows still occur. It changes `hi_pri`, `park_last` and `mtt_load` only every few hundred cycles, with the hold count kept small.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N_EXT     = 6,
  parameter int TW        = 8,
  parameter int DEAD_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] req_n,
  input  logic             bridge_req,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [N_EXT:0]   hi_pri,
  input  logic             park_last,
  input  logic [TW-1:0]    mtt_load,
  output logic [N_EXT-1:0] gnt_n,
  output logic             bridge_gnt
);
  localparam int NAG = N_EXT + 1;
  localparam int PW  = $clog2(NAG + 1);
  localparam int DW  = $clog2(DEAD_CLKS);
  localparam logic [NAG-1:0] HOME = {1'b1, {N_EXT{1'b0}}};

  logic [NAG-1:0] req_q, gnt, nxt_gnt, lo_cand;
  logic [NAG:0]   cand;
  logic [PW-1:0]  hp, lp, nxt_hp, nxt_lp;
  logic [TW-1:0]  cnt;
  logic [DW-1:0]  dcnt;
  logic           seen, idle, own_req, others, dead, rearb;

  assign idle    = frame_n & irdy_n;
  assign own_req = |(gnt & req_q);
  assign others  = |(req_q & ~gnt);
  assign dead    = own_req & ~seen & (dcnt == DW'(DEAD_CLKS - 1));
  assign rearb   = ~own_req | (idle & (dead | ((cnt == '0) & others)));
  assign lo_cand = req_q & ~hi_pri;
  assign cand    = {|lo_cand, req_q & hi_pri};

  always_comb begin
    int bh, bl, hw, lw, d;
    bh = NAG + 1; hw = 0;
    for (int i = 0; i <= NAG; i++) begin
      d = (i + NAG - int'(hp)) % (NAG + 1);
      if (cand[i] && d < bh) begin bh = d; hw = i; end
    end
    bl = NAG; lw = 0;
    for (int i = 0; i < NAG; i++) begin
      d = (i + NAG - 1 - int'(lp)) % NAG;
      if (lo_cand[i] && d < bl) begin bl = d; lw = i; end
    end
    nxt_hp = PW'(hw);
    nxt_lp = (hw == NAG) ? PW'(lw) : lp;
    nxt_gnt = '0;
    for (int i = 0; i < NAG; i++)
      nxt_gnt[i] = (hw == NAG) ? (lw == i) : (hw == i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      gnt   <= HOME;
      hp    <= PW'(NAG);
      lp    <= PW'(NAG - 1);
      cnt   <= '0;
      dcnt  <= '0;
      seen  <= 1'b0;
    end else begin
      req_q <= {bridge_req, ~req_n};
      if (rearb) begin
        dcnt <= '0;
        seen <= 1'b0;
        if (|cand) begin
          gnt <= nxt_gnt;
          hp  <= nxt_hp;
          lp  <= nxt_lp;
          cnt <= mtt_load;
        end else begin
          gnt <= park_last ? gnt : HOME;
          cnt <= '0;
        end
      end else begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        if (!frame_n) seen <= 1'b1;
        if (own_req && !seen && dcnt != DW'(DEAD_CLKS - 1)) dcnt <= dcnt + 1'b1;
      end
    end
  end

  assign gnt_n      = ~gnt[N_EXT-1:0];
  assign bridge_gnt = gnt[N_EXT];

  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(gnt));

  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && own_req) |=> $stable(gnt));

  a_r8_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && own_req && !dead) |=> $stable(gnt));

  a_r5_park_home: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == '0 && !park_last) |=> (gnt == HOME));

  a_r9_drop_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_req && req_q != '0) |=> |(gnt & $past(req_q)));

  a_r10_dead_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (dead && idle && others) |=> !$stable(gnt));
endmodule

// File: tb/sim_bus_arbiter.sv
`timescale 1ns/1ps
module sim_bus_arbiter;
  localparam int NA = 7;
  localparam logic [6:0] HOME = 7'b1000000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, bridge_req, frame_n, irdy_n, park_last, bridge_gnt;
  logic [5:0] req_n, gnt_n;
  logic [6:0] hi;
  logic [7:0] mtt;

  bus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .bridge_req(bridge_req),
    .frame_n(frame_n), .irdy_n(irdy_n), .hi_pri(hi), .park_last(park_last),
    .mtt_load(mtt), .gnt_n(gnt_n), .bridge_gnt(bridge_gnt)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [6:0] m_req, m_gnt;
  int m_hp, m_lp, m_cnt, m_dcnt;
  bit m_seen;

  function automatic logic [6:0] gvec();
    return {bridge_gnt, ~gnt_n};
  endfunction

  function automatic logic [6:0] ag(int i);
    return 7'(1) << i;
  endfunction

  task automatic model_step();
    bit idl, own, oth, dd, re;
    int win, lw;
    idl = frame_n && irdy_n;
    own = |(m_gnt & m_req);
    oth = |(m_req & ~m_gnt);
    dd  = own && !m_seen && m_dcnt == 15;
    re  = !own || (idl && (dd || (m_cnt == 0 && oth)));
    if (re) begin
      m_dcnt = 0; m_seen = 0;
      if (m_req != 0) begin
        win = -1;
        for (int k = 1; k <= NA + 1 && win < 0; k++) begin
          int s = (m_hp + k) % (NA + 1);
          if (s < NA) begin
            if (hi[s] && m_req[s]) win = s;
          end else if ((m_req & ~hi) != 0) win = s;
        end
        m_hp = win;
        if (win == NA) begin
          lw = -1;
          for (int k = 1; k <= NA && lw < 0; k++) begin
            int a = (m_lp + k) % NA;
            if (!hi[a] && m_req[a]) lw = a;
          end
          m_lp = lw;
          m_gnt = ag(lw);
        end else m_gnt = ag(win);
        m_cnt = int'(mtt);
      end else begin
        if (!park_last) m_gnt = HOME;
        m_cnt = 0;
      end
    end else begin
      if (m_cnt != 0) m_cnt--;
      if (own && !m_seen && m_dcnt != 15) m_dcnt++;
      if (!frame_n) m_seen = 1;
    end
    m_req = {bridge_req, ~req_n};
  endtask

  task automatic chk(logic [6:0] exp, string tag);
    total++;
    if (gvec() !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d got %b exp %b", tag, cyc, gvec(), exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    cyc++;
    chk(m_gnt, "R3/R4 model");
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; req_n = '1; bridge_req = 0; frame_n = 1; irdy_n = 1;
    hi = '1; park_last = 0; mtt = 0;
    m_req = 0; m_gnt = HOME; m_hp = 7; m_lp = 6; m_cnt = 0; m_dcnt = 0; m_seen = 0;
    repeat (3) @(negedge clk);
    chk(HOME, "R2 reset");
    rst_n = 1;

    req_n = 6'b111011;                       // R1
    tick(); chk(HOME, "R1 first edge");
    tick(); chk(ag(2), "R1 second edge");

    req_n = 6'b101010;                       // R3
    tick(); chk(ag(2), "R3");
    tick(); chk(ag(4), "R3");
    tick(); chk(ag(0), "R3");
    tick(); chk(ag(2), "R3");

    req_n = '1;
    repeat (3) tick();
    hi = 7'b1000001; req_n = 6'b110100;      // R4
    tick(); chk(HOME, "R4");
    tick(); chk(ag(1), "R4");
    tick(); chk(ag(0), "R4");
    tick(); chk(ag(3), "R4");
    tick(); chk(ag(0), "R4");
    tick(); chk(ag(1), "R4");

    park_last = 1; req_n = '1;               // R6
    repeat (3) tick();
    chk(ag(0), "R6");
    park_last = 0;                           // R5
    tick(); chk(HOME, "R5");

    hi = '1; mtt = 8'd5; req_n = 6'b110111;  // R8
    tick(); tick(); chk(ag(3), "R8");
    req_n = 6'b110101;
    repeat (5) tick();
    chk(ag(3), "R8 held");
    tick(); chk(ag(1), "R8 expiry");

    req_n = 6'b110111;                       // R9
    tick(); chk(ag(1), "R9");
    tick(); chk(ag(3), "R9");

    frame_n = 0; req_n = 6'b010111;          // R7
    repeat (8) tick();
    chk(ag(3), "R7 busy");
    frame_n = 1;
    tick(); chk(ag(5), "R7 idle");

    req_n = '1;                              // R10
    repeat (3) tick();
    mtt = 8'd255; req_n = 6'b011111;
    tick(); tick(); chk(ag(5), "R10");
    req_n = 6'b011011;
    repeat (15) tick();
    chk(ag(5), "R10 before");
    tick(); chk(ag(2), "R10 dead");

    mtt = 8'd2;
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) begin
        hi = 7'($urandom); park_last = 1'($urandom);
        mtt = 8'($urandom % 8);
      end
      if ($urandom % 4 == 0) begin
        req_n = 6'($urandom); bridge_req = ($urandom % 4) == 0;
      end
      frame_n = ($urandom % 4) != 0;
      irdy_n  = ($urandom % 4) != 0;
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule